// File: doc/BRIEF.md
# Clear-Only Flash Block Protection Register

This unit guards a small flash array split into equal blocks. It holds one read/execute enable bit for each block and a two-bit field that opens or closes the debug port. Software can only clear the enable bits, and never set them. A clear takes effect at once, but it stays temporary until software requests a commit. The commit copies the working word into a committed image. That image is kept in a register that no reset clears; it starts from the factory value through its power-up initial value. A power-on reset loads the working word from the committed image, so every uncommitted clear is undone.

A combinational checker takes a fetch or data address. It allows the access when the address lies inside the implemented flash range and the enable bit of its block is set. The debug-enable output is high only when the debug field holds the open code. The register answers on a simple bus at two word offsets. Every other offset reads zero and ignores writes.

Top module: `fprot_unit`

## Requirements
- R1: While `por` is high the working word is loaded from the committed image. The first image is the factory value 0x8000FFFF: bits 15:0 are all block enables set, and bits 31:30 hold debug code 2'b10.
- R2: A selected write sets the working word to old AND `reg_wdata` on bits 15:0 and 31:30. A 1 written to a cleared bit leaves it at 0.
- R3: Bits 29:16 always read as zero and ignore writes.
- R4: The register is selected at offsets 0x130 and 0x134 of `reg_addr`. Any other offset reads zero, and writes to it change nothing.
- R5: `reg_rdata` is registered. After the edge that samples `reg_addr`, it shows the working word from before any write made at that same edge. It is zero while `por` is high.
- R6: A power-on reset with no commit in between restores every bit cleared since the last load.
- R7: A one-cycle `commit_req` copies the working word into the committed image, and a later power-on reset reloads that word. The image never gains a set bit.
- R8: `chk_allow` equals enable bit `chk_addr[14:11]` (bit n guards the 2 KB block n) and changes combinationally.
- R9: Any `chk_addr` at or above 0x8000 (outside the 32 KB array) is denied.
- R10: `dbg_en` is high only when bits 31:30 equal 2'b10. Every other code, including 2'b00 reached by writing 0 to bit 31, disables debug.
- R11: While `por` is high, register writes and commit requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous active-high power-on reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| commit_req | input | 1 | One-cycle commit request |
| reg_rdata | output | 32 | Registered read data |
| chk_addr | input | 20 | Address under access check |
| chk_allow | output | 1 | Access allowed |
| dbg_en | output | 1 | Debug port enabled |

## Verification
The assertions assume that `por` is high from time zero through the first clock edges, so the working word has been loaded before any clear-only or reload property is evaluated. They also assume that `commit_req` comes as isolated pulses. The stimulus raises `por` before the first edge, and it changes every input only on falling edges. This keeps each write, commit and reset in one sampled cycle. Writes and commits made during reset are issued on purpose, so that the rule that they are ignored is actually exercised.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DBG_LSB  = 30;
  localparam logic [1:0]  DBG_OPEN = 2'b10;

  // bits software may clear: block enables and the debug field
  function automatic logic [WORD_W-1:0] writable_mask(input int unsigned nblk);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(nblk); i++) m[i] = 1'b1;
    m[DBG_LSB +: 2] = 2'b11;
    return m;
  endfunction
endpackage

// File: rtl/fprot_decode.sv
module fprot_decode #(
  parameter int unsigned AW        = 12,
  parameter logic [11:0] BASE      = 12'h130,
  parameter int unsigned NUM_ALIAS = 2
) (
  input  logic [AW-1:0] addr,
  output logic          sel
);
  logic [NUM_ALIAS-1:0] hit;

  generate
    for (genvar g = 0; g < int'(NUM_ALIAS); g++) begin : g_alias
      assign hit[g] = (addr == AW'(BASE + 12'(4 * g)));
    end
  endgenerate

  assign sel = |hit;
endmodule

// File: rtl/fprot_store.sv
module fprot_store
  import fprot_pkg::*;
#(
  parameter int unsigned NBLK = 16
) (
  input  logic              clk,
  input  logic              por,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              commit,
  output logic [WORD_W-1:0] work
);
  localparam logic [WORD_W-1:0] WMASK   = writable_mask(NBLK);
  localparam logic [WORD_W-1:0] FACTORY = WMASK & {DBG_OPEN, {(WORD_W-2){1'b1}}};

  logic [WORD_W-1:0] work_q;
  // committed image: power-up value only, no reset touches it
  logic [WORD_W-1:0] shadow_q = FACTORY;

  always_ff @(posedge clk) begin
    if (por) begin
      work_q <= shadow_q;
    end else if (wr_en) begin
      work_q <= work_q & (wdata | ~WMASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!por && commit) begin
      shadow_q <= shadow_q & work_q;
    end
  end

  assign work = work_q;

  assert_clear_only_R2: assert property (@(posedge clk) disable iff (por)
    !por |=> ((work_q & ~$past(work_q)) == '0));

  assert_image_no_gain_R7: assert property (@(posedge clk) disable iff (por)
    !por |=> ((shadow_q & ~$past(shadow_q)) == '0));

  assert_commit_copy_R7: assert property (@(posedge clk) disable iff (por)
    commit |=> (shadow_q == $past(work_q)));

  assert_reload_R1: assert property (@(posedge clk) disable iff (por)
    $fell(por) |-> (work_q == shadow_q));
endmodule

// File: rtl/fprot_check.sv
module fprot_check
  import fprot_pkg::*;
#(
  parameter int unsigned NBLK     = 16,
  parameter int unsigned BLK_LOG2 = 11,
  parameter int unsigned AW       = 20
) (
  input  logic [NBLK-1:0] en,
  input  logic [1:0]      dbg_field,
  input  logic [AW-1:0]   addr,
  output logic            allow,
  output logic            dbg_en
);
  localparam int unsigned IDX_W = $clog2(NBLK);
  localparam int unsigned TOP   = BLK_LOG2 + IDX_W;

  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic             unused_low;

  assign idx        = addr[BLK_LOG2 +: IDX_W];
  assign unused_low = ^addr[BLK_LOG2-1:0];

  generate
    if (AW > TOP) begin : g_upper
      assign in_range = (addr[AW-1:TOP] == '0);
    end else begin : g_flat
      assign in_range = 1'b1;
    end
  endgenerate

  assign allow  = in_range & en[idx];
  assign dbg_en = (dbg_field == DBG_OPEN);
endmodule

// File: rtl/fprot_unit.sv
module fprot_unit
  import fprot_pkg::*;
#(
  parameter int unsigned NBLK     = 16,
  parameter int unsigned BLK_LOG2 = 11,
  parameter int unsigned BUS_AW   = 12,
  parameter int unsigned CHK_AW   = 20
) (
  input  logic              clk,
  input  logic              por,
  input  logic [BUS_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              reg_we,
  input  logic              commit_req,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic [CHK_AW-1:0] chk_addr,
  output logic              chk_allow,
  output logic              dbg_en
);
  localparam int unsigned SPAN_LOG2 = BLK_LOG2 + $clog2(NBLK);

  logic              sel;
  logic [WORD_W-1:0] work;

  fprot_decode #(.AW(BUS_AW), .BASE(12'h130), .NUM_ALIAS(2)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  fprot_store #(.NBLK(NBLK)) u_store (
    .clk    (clk),
    .por    (por),
    .wr_en  (reg_we & sel),
    .wdata  (reg_wdata),
    .commit (commit_req),
    .work   (work)
  );

  fprot_check #(.NBLK(NBLK), .BLK_LOG2(BLK_LOG2), .AW(CHK_AW)) u_chk (
    .en        (work[NBLK-1:0]),
    .dbg_field (work[DBG_LSB +: 2]),
    .addr      (chk_addr),
    .allow     (chk_allow),
    .dbg_en    (dbg_en)
  );

  always_ff @(posedge clk) begin
    if (por) reg_rdata <= '0;
    else     reg_rdata <= sel ? work : '0;
  end

  assert_foreign_write_R4: assert property (@(posedge clk) disable iff (por)
    (reg_we && !sel) |=> (work == $past(work)));

  assert_deny_high_R9: assert property (@(posedge clk) disable iff (por)
    (chk_addr >= CHK_AW'(1 << SPAN_LOG2)) |-> !chk_allow);

  assert_dbg_sticky_R10: assert property (@(posedge clk) disable iff (por)
    (!dbg_en && !por) |=> !dbg_en);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (por)
    1'b1 |-> (reg_rdata[DBG_LSB-1:NBLK] == '0));
endmodule

// File: tb/sim_fprot_unit.sv
module sim_fprot_unit;
  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        commit_req = 1'b0;
  logic [31:0] reg_rdata;
  logic [19:0] chk_addr = '0;
  logic        chk_allow;
  logic        dbg_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fprot_unit u0 (
    .clk(clk), .por(por), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .commit_req(commit_req), .reg_rdata(reg_rdata),
    .chk_addr(chk_addr), .chk_allow(chk_allow), .dbg_en(dbg_en)
  );

  // write address, write data, expected word read back at 0x130 afterwards
  localparam logic [11:0] VA [0:6] = '{12'h130, 12'h134, 12'h138, 12'h130,
                                       12'h130, 12'h12C, 12'h130};
  localparam logic [31:0] VD [0:6] = '{32'hFFFF_FFFE, 32'hFFFF_7FFF, 32'h0000_0000,
                                       32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_0000,
                                       32'hFFFF_00FF};
  localparam logic [31:0] VE [0:6] = '{32'h8000_FFFE, 32'h8000_7FFE, 32'h8000_7FFE,
                                       32'h0000_7FFE, 32'h0000_7FFE, 32'h0000_7FFE,
                                       32'h0000_00FE};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] r);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(posedge clk);
    #1 r = reg_rdata;
  endtask

  task automatic pulse_por();
    @(negedge clk);
    por = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0;
  endtask

  task automatic do_commit();
    @(negedge clk);
    commit_req = 1'b1;
    @(negedge clk);
    commit_req = 1'b0;
  endtask

  task automatic allow_at(input logic [19:0] a, input logic exp, input string tag);
    chk_addr = a;
    #1 check(tag, {31'd0, chk_allow}, {31'd0, exp});
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, remaining requirements unchecked");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R5 rdata zero in reset", reg_rdata, 32'h0);
    por = 1'b0;

    rd(12'h130, r);
    check("R1 factory image", r, 32'h8000_FFFF);
    check("R10 debug open after load", {31'd0, dbg_en}, 32'd1);
    @(negedge clk);
    allow_at(20'h00000, 1'b1, "R8 block0 open");

    for (int i = 0; i < 7; i++) begin
      wr(VA[i], VD[i]);
      rd(12'h130, r);
      check($sformatf("R2 R3 R4 vector %0d", i), r, VE[i]);
    end

    rd(12'h134, r);
    check("R4 alias read", r, 32'h0000_00FE);
    rd(12'h138, r);
    check("R4 foreign offset reads zero", r, 32'h0);
    @(negedge clk);
    allow_at(20'h00000, 1'b0, "R8 block0 cleared");
    allow_at(20'h00800, 1'b1, "R8 block1 open");
    allow_at(20'h04000, 1'b0, "R8 block8 cleared");
    allow_at(20'h07800, 1'b0, "R8 block15 cleared");
    check("R10 debug closed by code 00", {31'd0, dbg_en}, 32'd0);

    pulse_por();
    rd(12'h130, r);
    check("R6 uncommitted clears undone", r, 32'h8000_FFFF);
    check("R6 debug restored", {31'd0, dbg_en}, 32'd1);

    wr(12'h130, 32'hFFFF_FFF7);
    do_commit();
    wr(12'h130, 32'hFFFF_FFEF);
    rd(12'h130, r);
    check("R2 second clear", r, 32'h8000_FFE7);
    pulse_por();
    rd(12'h130, r);
    check("R7 committed image reloaded", r, 32'h8000_FFF7);
    @(negedge clk);
    allow_at(20'h01800, 1'b0, "R7 R8 block3 kept cleared");
    allow_at(20'h02000, 1'b1, "R7 R8 block4 restored");

    @(negedge clk);
    por = 1'b1; reg_addr = 12'h130; reg_wdata = 32'h0; reg_we = 1'b1; commit_req = 1'b1;
    repeat (2) @(negedge clk);
    por = 1'b0; reg_we = 1'b0; commit_req = 1'b0;
    rd(12'h130, r);
    check("R11 write in reset ignored", r, 32'h8000_FFF7);
    pulse_por();
    rd(12'h130, r);
    check("R11 commit in reset ignored", r, 32'h8000_FFF7);

    @(negedge clk);
    reg_addr = 12'h130; reg_wdata = 32'hFFFF_FFDF; reg_we = 1'b1;
    @(posedge clk);
    #1 check("R5 read shows pre-write word", reg_rdata, 32'h8000_FFF7);
    @(negedge clk);
    reg_we = 1'b0;
    @(posedge clk);
    #1 check("R5 read shows written word", reg_rdata, 32'h8000_FFD7);

    @(negedge clk);
    allow_at(20'h08800, 1'b0, "R9 above range");
    allow_at(20'hFFFFF, 1'b0, "R9 top address");
    allow_at(20'h00800, 1'b1, "R9 in range control");

    wr(12'h130, 32'h7FFF_FFFF);
    rd(12'h130, r);
    check("R10 debug field cleared", r, 32'h0000_FFD7);
    check("R10 debug disabled", {31'd0, dbg_en}, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule